// File: doc/BRIEF.md
# Serial Character Timing Engine

This block times whole serial characters for a port whose frame format is set at run time. From a baud divisor split across a high and a low byte, a speed-doubling select, a character-size code, a parity enable and a stop-bit select, it works out how many clock cycles one character occupies on the line. It does not produce the line waveform. It only tells the surrounding logic when a character would have finished.

The transmit side takes a start strobe. It holds a busy flag while the character is timing and then gives a one-cycle completion pulse. That pulse stands for both "holding register empty" and "transmission complete". The receive side takes a start strobe together with a byte. It accepts the request only when the receiver is enabled and not already busy, and otherwise answers with a refusal pulse. An accepted byte is masked to the character width and is presented on the output, with a completion pulse, once one character time has passed.

Top module: `uart_char_timing`

## Requirements
- R1: After reset both busy flags are low, all strobes (tx_done, rx_done, rx_reject) are low and rx_byte is 0.
- R2: One character lasts (divisor + 1) × multiplier × symbols cycles, where symbols = 1 start + data bits + stop bits + 1 if parity is enabled.
- R3: The multiplier is 8 when cfg_double is 1 and 16 when it is 0.
- R4: The divisor is {cfg_div_hi, cfg_div_lo}, with the high byte above bit 7.
- R5: cfg_two_stop=1 gives 2 stop bits and 0 gives 1. cfg_parity_en=1 adds one symbol.
- R6: cfg_size codes 0,1,2,3 give 5,6,7,8 data bits. Codes 4 to 7 give 9 data bits.
- R7: tx_start sampled at a rising edge raises tx_busy at that edge. Exactly N edges later (N = cycles per character), tx_busy falls and tx_done is high for one cycle.
- R8: A tx_start while tx_busy is high restarts the count from that edge. Only one tx_done follows, N cycles after the last start.
- R9: An rx_start sampled while rx_enable=1 and rx_busy=0 raises rx_busy. N edges later, rx_busy falls, rx_done pulses for one cycle and rx_byte takes the captured data.
- R10: An rx_start sampled while rx_busy=1 or rx_enable=0 is refused. rx_reject pulses at the next edge, and the timing and rx_byte are not affected.
- R11: The configuration is taken at the start edge of each character. Changing it during the character does not change that character's duration.
- R12: rx_byte holds rx_data masked to the character width captured at the start (5 bits→0x1F, 6→0x3F, 7→0x7F, 8 or 9→0xFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div_hi | input | DIV_W-8 | Upper bits of the baud divisor |
| cfg_div_lo | input | 8 | Lower byte of the baud divisor |
| cfg_double | input | 1 | Speed doubling, multiplier 8 instead of 16 |
| cfg_size | input | 3 | Character-size code |
| cfg_parity_en | input | 1 | Parity symbol present |
| cfg_two_stop | input | 1 | Two stop bits |
| rx_enable | input | 1 | Receiver enabled |
| tx_start | input | 1 | Start (or restart) a transmit character |
| rx_start | input | 1 | Request to receive a byte |
| rx_data | input | 8 | Byte offered with rx_start |
| tx_busy | output | 1 | Transmit character timing |
| tx_done | output | 1 | One-cycle transmit completion pulse |
| rx_busy | output | 1 | Receive character timing |
| rx_done | output | 1 | One-cycle receive completion pulse |
| rx_reject | output | 1 | One-cycle refusal of an rx_start |
| rx_byte | output | 8 | Last received byte, masked |

## Verification
The hardest conditions to create are those where a second event lands inside a character that is already timing. These are a transmit restart, a receive request while busy, and a configuration change partway through. The directed tasks count edges from a known start and inject the second event a fixed number of cycles later. They then check both that no early completion appears and that the final completion lands exactly one full character after the edge that should govern it. The refused request carries a different byte, so any leak of it would show up on rx_byte.

// File: rtl/uart_timing_pkg.sv
package uart_timing_pkg;

    localparam int DIV_W   = 12;
    localparam int MULT_LW = 4;                 // log2 of the largest multiplier (16)
    localparam int SYM_W   = 4;                 // up to 13 symbols
    localparam int CNT_W   = DIV_W + 1 + MULT_LW + SYM_W;
    localparam int MIN_CYC = 8 * 7;             // divisor 0, x8, 5N1

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             dbl;
        logic [2:0]       size;
        logic             par_en;
        logic             two_stop;
    } frame_cfg_t;

    function automatic logic [3:0] data_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd5;
            3'd1:    return 4'd6;
            3'd2:    return 4'd7;
            3'd3:    return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

    function automatic logic [SYM_W-1:0] symbols(input frame_cfg_t c);
        return SYM_W'(4'd1 + data_bits(c.size) + (c.two_stop ? 4'd2 : 4'd1)
                      + {3'd0, c.par_en});
    endfunction

    function automatic logic [7:0] width_mask(input logic [2:0] code);
        logic [3:0] b;
        b = data_bits(code);
        if (b >= 4'd8) return 8'hFF;
        return 8'((9'd1 << b) - 9'd1);
    endfunction

endpackage

// File: rtl/uart_frame_calc.sv
module uart_frame_calc
    import uart_timing_pkg::*;
(
    input  frame_cfg_t       cfg,
    output logic [CNT_W-1:0] cycles
);
    logic [CNT_W-1:0] per_symbol;

    always_comb begin
        per_symbol = (CNT_W'(cfg.div) + CNT_W'(1)) << (cfg.dbl ? 3 : MULT_LW);
        cycles     = per_symbol * CNT_W'(symbols(cfg));
    end
endmodule

// File: rtl/uart_char_timer.sv
module uart_char_timer #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             last,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    assign last = busy && (cnt == '0) && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cnt  <= load_val - CNT_W'(1);
                busy <= 1'b1;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                   // R7
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);                             // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy || $past(start));                   // R8
endmodule

// File: rtl/uart_char_timing.sv
module uart_char_timing
    import uart_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-9:0] cfg_div_hi,
    input  logic [7:0]       cfg_div_lo,
    input  logic             cfg_double,
    input  logic [2:0]       cfg_size,
    input  logic             cfg_parity_en,
    input  logic             cfg_two_stop,
    input  logic             rx_enable,
    input  logic             tx_start,
    input  logic             rx_start,
    input  logic [7:0]       rx_data,
    output logic             tx_busy,
    output logic             tx_done,
    output logic             rx_busy,
    output logic             rx_done,
    output logic             rx_reject,
    output logic [7:0]       rx_byte
);
    frame_cfg_t       cfg;
    logic [CNT_W-1:0] char_cycles;
    logic             rx_accept;
    logic             rx_last;
    logic             tx_last;
    logic [7:0]       rx_pend;

    always_comb begin
        cfg.div      = {cfg_div_hi, cfg_div_lo};
        cfg.dbl      = cfg_double;
        cfg.size     = cfg_size;
        cfg.par_en   = cfg_parity_en;
        cfg.two_stop = cfg_two_stop;
    end

    uart_frame_calc u_calc (
        .cfg    (cfg),
        .cycles (char_cycles)
    );

    uart_char_timer #(.CNT_W(CNT_W)) u_tx_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (tx_start),
        .load_val (char_cycles),
        .busy     (tx_busy),
        .last     (tx_last),
        .done     (tx_done)
    );

    assign rx_accept = rx_start && rx_enable && !rx_busy;

    uart_char_timer #(.CNT_W(CNT_W)) u_rx_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (rx_accept),
        .load_val (char_cycles),
        .busy     (rx_busy),
        .last     (rx_last),
        .done     (rx_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_pend   <= '0;
            rx_byte   <= '0;
            rx_reject <= 1'b0;
        end else begin
            rx_reject <= rx_start && !rx_accept;
            if (rx_accept) rx_pend <= rx_data & width_mask(cfg_size);
            if (rx_last)   rx_byte <= rx_pend;
        end
    end

    AST_CYC_FLOOR: assert property (@(posedge clk) disable iff (rst)
        char_cycles >= CNT_W'(MIN_CYC));                   // R2
    AST_RX_REJECT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rx_reject |-> ($past(rx_busy) || !$past(rx_enable))); // R10
    AST_RX_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> !rx_busy);                             // R9
    AST_RX_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> $stable(rx_byte));                    // R9
    AST_TX_LAST_DONE: assert property (@(posedge clk) disable iff (rst)
        tx_last |=> tx_done);                              // R7
endmodule

// File: tb/tb_uart_char_timing.sv
module tb_uart_char_timing;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cfg_div_hi = '0;
    logic [7:0] cfg_div_lo = '0;
    logic       cfg_double = 1'b0;
    logic [2:0] cfg_size = 3'd3;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       rx_enable = 1'b0;
    logic       tx_start = 1'b0;
    logic       rx_start = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_busy, tx_done, rx_busy, rx_done, rx_reject;
    logic [7:0] rx_byte;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_char_timing dut (
        .clk(clk), .rst(rst), .cfg_div_hi(cfg_div_hi), .cfg_div_lo(cfg_div_lo),
        .cfg_double(cfg_double), .cfg_size(cfg_size), .cfg_parity_en(cfg_parity_en),
        .cfg_two_stop(cfg_two_stop), .rx_enable(rx_enable), .tx_start(tx_start),
        .rx_start(rx_start), .rx_data(rx_data), .tx_busy(tx_busy), .tx_done(tx_done),
        .rx_busy(rx_busy), .rx_done(rx_done), .rx_reject(rx_reject), .rx_byte(rx_byte)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_cycles(input int div, input bit dbl, input int code,
                                      input bit par, input bit two);
        int bits;
        bits = (code < 4) ? code + 5 : 9;
        return (div + 1) * (dbl ? 8 : 16) * (1 + bits + (two ? 2 : 1) + (par ? 1 : 0));
    endfunction

    task automatic set_cfg(input int div, input bit dbl, input int code,
                           input bit par, input bit two);
        cfg_div_hi    = 4'(div >> 8);
        cfg_div_lo    = 8'(div);
        cfg_double    = dbl;
        cfg_size      = 3'(code);
        cfg_parity_en = par;
        cfg_two_stop  = two;
    endtask

    // pulse tx_start for one edge, then count edges until tx_done
    task automatic tx_measure(input string req, input int exp);
        int n;
        n = 0;
        tx_start = 1'b1;
        @(posedge clk); @(negedge clk);
        tx_start = 1'b0;
        n = 1;
        check({req, " busy after start"}, int'(tx_busy), 1);
        while (!tx_done && n < exp + 5) begin
            @(posedge clk); @(negedge clk); n++;
        end
        check({req, " tx cycles"}, n - 1, exp);
        check({req, " busy cleared at done"}, int'(tx_busy), 0);
        @(posedge clk); @(negedge clk);
        check({req, " done one cycle"}, int'(tx_done), 0);
    endtask

    task automatic test_reset();
        check("R1 tx_busy", int'(tx_busy), 0);
        check("R1 rx_busy", int'(rx_busy), 0);
        check("R1 strobes", int'({tx_done, rx_done, rx_reject}), 0);
        check("R1 rx_byte", int'(rx_byte), 0);
    endtask

    task automatic test_tx_formats();
        set_cfg(0, 0, 3, 0, 0);
        tx_measure("R2 8N1 div0", exp_cycles(0, 0, 3, 0, 0));
        set_cfg(2, 1, 3, 0, 0);
        tx_measure("R3 double div2", exp_cycles(2, 1, 3, 0, 0));
        set_cfg(256, 1, 0, 1, 1);
        tx_measure("R4 R5 hi byte 5E2", exp_cycles(256, 1, 0, 1, 1));
        set_cfg(1, 1, 7, 1, 0);
        tx_measure("R6 code7 nine bits", exp_cycles(1, 1, 7, 1, 0));
        set_cfg(0, 0, 5, 0, 1);
        tx_measure("R6 code5 nine bits", exp_cycles(0, 0, 5, 0, 1));
    endtask

    task automatic test_tx_restart();
        int n, dones, exp;
        set_cfg(0, 1, 3, 0, 0);
        exp = exp_cycles(0, 1, 3, 0, 0);
        dones = 0;
        tx_start = 1'b1; @(posedge clk); @(negedge clk); tx_start = 1'b0;
        repeat (30) begin @(posedge clk); @(negedge clk); if (tx_done) dones++; end
        tx_start = 1'b1; @(posedge clk); @(negedge clk); tx_start = 1'b0;
        n = 1;
        while (!tx_done && n < exp + 5) begin @(posedge clk); @(negedge clk); n++; end
        if (tx_done) dones++;
        check("R8 restart cycles", n - 1, exp);
        repeat (exp + 5) begin @(posedge clk); @(negedge clk); if (tx_done) dones++; end
        check("R8 single done", dones, 1);
    endtask

    task automatic test_cfg_hold();
        int n, exp;
        set_cfg(1, 1, 3, 0, 0);
        exp = exp_cycles(1, 1, 3, 0, 0);
        tx_start = 1'b1; @(posedge clk); @(negedge clk); tx_start = 1'b0;
        set_cfg(5, 0, 7, 1, 1);
        n = 1;
        while (!tx_done && n < exp + 5) begin @(posedge clk); @(negedge clk); n++; end
        check("R11 cfg held during char", n - 1, exp);
    endtask

    task automatic test_rx();
        int n, exp;
        rx_enable = 1'b1;
        set_cfg(0, 1, 0, 0, 0);
        exp = exp_cycles(0, 1, 0, 0, 0);
        rx_data = 8'hAB;
        rx_start = 1'b1; @(posedge clk); @(negedge clk); rx_start = 1'b0;
        check("R9 rx busy", int'(rx_busy), 1);
        check("R10 accepted no reject", int'(rx_reject), 0);
        set_cfg(0, 1, 3, 0, 0);
        // second request while busy, different byte
        rx_data = 8'h55;
        rx_start = 1'b1; @(posedge clk); @(negedge clk); rx_start = 1'b0;
        check("R10 reject while busy", int'(rx_reject), 1);
        n = 2;
        while (!rx_done && n < exp + 5) begin
            check("R10 rx_byte untouched", int'(rx_byte), 0);
            @(posedge clk); @(negedge clk); n++;
        end
        check("R9 rx cycles", n - 1, exp);
        check("R12 masked 5-bit byte", int'(rx_byte), 8'h0B);
        check("R9 busy clear", int'(rx_busy), 0);
        @(posedge clk); @(negedge clk);
        check("R9 rx_done one cycle", int'(rx_done), 0);
        // disabled receiver
        rx_enable = 1'b0;
        rx_data = 8'hFF;
        rx_start = 1'b1; @(posedge clk); @(negedge clk); rx_start = 1'b0;
        check("R10 reject disabled", int'(rx_reject), 1);
        check("R10 disabled no busy", int'(rx_busy), 0);
        repeat (exp + 5) @(posedge clk);
        @(negedge clk);
        check("R10 disabled byte kept", int'(rx_byte), 8'h0B);
        // 9-bit width keeps full byte
        rx_enable = 1'b1;
        set_cfg(0, 1, 7, 0, 0);
        exp = exp_cycles(0, 1, 7, 0, 0);
        rx_data = 8'hC7;
        rx_start = 1'b1; @(posedge clk); @(negedge clk); rx_start = 1'b0;
        n = 1;
        while (!rx_done && n < exp + 5) begin @(posedge clk); @(negedge clk); n++; end
        check("R9 rx nine-bit cycles", n - 1, exp);
        check("R12 full byte", int'(rx_byte), 8'hC7);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_tx_formats();
        test_tx_restart();
        test_cfg_hold();
        test_rx();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule